// File: doc/BRIEF.md
# Parallel Port Mode Negotiation Controller

This block is the host side of the handshake that moves a bidirectional parallel link out of compatibility mode into an extended mode, and later back again. It drives the select line, the host-busy line, the strobe line and the eight data lines. It watches five status lines from the peripheral: its clock, its busy, its acknowledge-data-request, its extension flag and its active-low data-available line. Every status line passes through a multi-stage synchronizer before the state machine reads it.

An entry request puts the requested extensibility code on the data lines and raises select. It then waits for the peripheral to answer and strobes the code in. When the peripheral's clock returns high, the link counts as connected. A terminate request drops select and clears the data lines. It then runs the closing handshake and always finishes with host-busy high, so the link is back in compatibility mode. Each peripheral wait has a bounded timeout derived from the clock frequency. Each run ends with a one-cycle completion pulse, together with held success and timeout flags.

Top module: `pport_neg_ctrl`

## Requirements
- R1: After reset: select is low, host-busy is high, strobe is high, the data lines are zero, connected is low and the completion pulse is low.
- R2: On an entry request, the code is driven onto the data lines at least one setup delay before select goes high and host-busy goes low. Strobe stays high while this happens.
- R3: After select rises, the strobe does not fall until all four of these hold at once: peripheral clock low, acknowledge-data-request high, extension flag high and data-available (active low) high.
- R4: The strobe is low only while host-busy is low and select is high. It stays low for at least the strobe-width parameter in cycles. It is released in the same cycle that host-busy goes high.
- R5: Once the strobe is released, the peripheral clock going high ends the entry with a completion pulse, success set and connected set. Select stays high.
- R6: If the peripheral does not answer within the response timeout, either before the strobe or after it, the entry ends with a completion pulse and timeout set. Success and connected are cleared, select is low and host-busy is high.
- R7: On a terminate request, select goes low and the data lines go to zero. Host-busy and strobe stay high.
- R8: The closing handshake advances only when the peripheral clock is low. For mode codes 0 (nibble), 1 (byte) and 2 (ECP), with the ignore-flag input at 0, the extension flag must also be the inverse of its level at the moment the request was accepted. With mode code 3, or with the ignore-flag input at 1, the flag is not examined.
- R9: Once that condition holds, host-busy goes low. The block then waits for peripheral busy high and peripheral clock high. It raises host-busy again and completes with success, and connected cleared.
- R10: If the closing condition does not arrive within the timeout, host-busy never goes low. The run completes with timeout set, host-busy high and connected cleared.
- R11: A terminate request while the link is already in compatibility mode is ignored. This includes the state after reset and the state after a completed termination. No completion pulse is produced and no line changes.
- R12: The completion pulse lasts exactly one cycle. When it is high, exactly one of success and timeout is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enter_req_i | input | 1 | Start an entry handshake (taken when idle) |
| term_req_i | input | 1 | Start a termination handshake (taken when idle and not in compatibility mode) |
| ext_code_i | input | DATA_W | Extensibility code sent during entry |
| mode_i | input | 2 | Active mode: 0 nibble, 1 byte, 2 ECP, 3 other |
| xflag_ignore_i | input | 1 | Skip the extension-flag test during termination |
| peer_clk_i | input | 1 | Peripheral clock line |
| peer_busy_i | input | 1 | Peripheral busy line |
| peer_ackreq_i | input | 1 | Peripheral acknowledge-data-request line |
| peer_flag_i | input | 1 | Peripheral extension flag line |
| peer_avail_n_i | input | 1 | Peripheral data-available line, active low |
| sel_o | output | 1 | Host select line |
| hbusy_o | output | 1 | Host busy line |
| hstb_n_o | output | 1 | Host strobe, active low |
| data_o | output | DATA_W | Host data lines |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Last run succeeded |
| timeout_o | output | 1 | Last run ended by timeout |
| connected_o | output | 1 | Link is in the negotiated mode |

## Verification
The hardest case to reach is a termination that stalls on the extension flag alone. The peripheral clock has already gone low, but the flag has not yet inverted, so the block must hold host-busy high without timing out. The bench first completes a real entry so the block leaves compatibility mode. It then lowers the peripheral clock while keeping the flag at its pre-request level, and observes host-busy over a window shorter than the timeout before flipping the flag. The same staged stimulus is used during entry: three of the four required status levels are presented first, and the strobe is shown to stay high until the fourth arrives.

// File: rtl/pport_neg_pkg.sv
package pport_neg_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_N_PREP,
      ST_N_CODE,
      ST_N_REQ,
      ST_N_WAIT_ACK,
      ST_N_STROBE,
      ST_N_WAIT_CLK,
      ST_N_FAIL,
      ST_N_OK,
      ST_T_START,
      ST_T_WAIT_CLK,
      ST_T_WAIT_BUSY,
      ST_T_FINISH
   } neg_state_e;

   typedef enum logic [1:0] {
      MODE_NIBBLE = 2'd0,
      MODE_BYTE   = 2'd1,
      MODE_ECP    = 2'd2,
      MODE_OTHER  = 2'd3
   } link_mode_e;

   typedef enum logic [1:0] {
      LIM_SETUP,
      LIM_STROBE,
      LIM_RESP
   } lim_sel_e;

   typedef struct packed {
      logic clk;
      logic busy;
      logic ackreq;
      logic flag;
      logic avail_n;
   } peer_stat_t;

   function automatic int unsigned ns2cyc(input int unsigned hz, input int unsigned ns);
      longint unsigned prod;
      prod = longint'(hz) * longint'(ns) + 64'd999_999_999;
      return int'(prod / 64'd1_000_000_000);
   endfunction

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
   parameter int unsigned W      = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/pport_timer.sv
module pport_timer
   import pport_neg_pkg::*;
#(
   parameter int unsigned CW         = 8,
   parameter int unsigned SETUP_CYC  = 4,
   parameter int unsigned STROBE_CYC = 2,
   parameter int unsigned RESP_CYC   = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr,
   input  lim_sel_e sel,
   output logic     hit
);

   localparam logic [CW-1:0] SETUP_LAST  = CW'(SETUP_CYC - 1);
   localparam logic [CW-1:0] STROBE_LAST = CW'(STROBE_CYC - 1);
   localparam logic [CW-1:0] RESP_LAST   = CW'(RESP_CYC - 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] last;

   always_comb begin
      unique case (sel)
         LIM_SETUP:  last = SETUP_LAST;
         LIM_STROBE: last = STROBE_LAST;
         default:    last = RESP_LAST;
      endcase
   end

   assign hit = (cnt >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (!hit)   cnt <= cnt + CW'(1);
   end

endmodule

// File: rtl/pport_neg_fsm.sv
module pport_neg_fsm
   import pport_neg_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enter_req,
   input  logic              term_req,
   input  logic [DATA_W-1:0] ext_code,
   input  logic [1:0]        mode,
   input  logic              xflag_ignore,
   input  peer_stat_t        stat,
   input  logic              tmr_hit,
   output logic              tmr_clr,
   output lim_sel_e          lim_sel,
   output logic              sel,
   output logic              hbusy,
   output logic              hstb_n,
   output logic [DATA_W-1:0] data,
   output logic              done,
   output logic              ok,
   output logic              timeout,
   output logic              connected
);

   neg_state_e        st, nxt;
   logic [DATA_W-1:0] code_q;
   logic              compat_q;
   logic              flag_ref_q;
   logic              use_flag_q;
   logic              tmo_seen_q;
   logic              ack_ready;
   logic              close_ready;
   logic              release_ready;

   assign ack_ready     = !stat.clk && stat.ackreq && stat.flag && stat.avail_n;
   assign close_ready   = !stat.clk && (!use_flag_q || (stat.flag != flag_ref_q));
   assign release_ready = stat.clk && stat.busy;

   always_comb begin
      nxt = st;
      unique case (st)
         ST_IDLE: begin
            if (enter_req)                 nxt = ST_N_PREP;
            else if (term_req && !compat_q) nxt = ST_T_START;
         end
         ST_N_PREP:      if (tmr_hit) nxt = ST_N_CODE;
         ST_N_CODE:      if (tmr_hit) nxt = ST_N_REQ;
         ST_N_REQ:       nxt = ST_N_WAIT_ACK;
         ST_N_WAIT_ACK: begin
            if (ack_ready)    nxt = ST_N_STROBE;
            else if (tmr_hit) nxt = ST_N_FAIL;
         end
         ST_N_STROBE:    if (tmr_hit) nxt = ST_N_WAIT_CLK;
         ST_N_WAIT_CLK: begin
            if (stat.clk)     nxt = ST_N_OK;
            else if (tmr_hit) nxt = ST_N_FAIL;
         end
         ST_N_FAIL:      nxt = ST_IDLE;
         ST_N_OK:        nxt = ST_IDLE;
         ST_T_START:     nxt = ST_T_WAIT_CLK;
         ST_T_WAIT_CLK: begin
            if (close_ready)  nxt = ST_T_WAIT_BUSY;
            else if (tmr_hit) nxt = ST_T_FINISH;
         end
         ST_T_WAIT_BUSY: begin
            if (release_ready || tmr_hit) nxt = ST_T_FINISH;
         end
         ST_T_FINISH:    nxt = ST_IDLE;
         default:        nxt = ST_IDLE;
      endcase
   end

   always_comb begin
      unique case (st)
         ST_N_PREP, ST_N_CODE: lim_sel = LIM_SETUP;
         ST_N_STROBE:          lim_sel = LIM_STROBE;
         default:              lim_sel = LIM_RESP;
      endcase
   end

   assign tmr_clr = (nxt != st);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= nxt;
   end

   // Line drive on state entry; lines hold in every other cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel    <= 1'b0;
         hbusy  <= 1'b1;
         hstb_n <= 1'b1;
         data   <= '0;
      end else if (nxt != st) begin
         unique case (nxt)
            ST_N_PREP: begin
               sel    <= 1'b0;
               hbusy  <= 1'b1;
               hstb_n <= 1'b1;
            end
            ST_N_CODE:      data   <= code_q;
            ST_N_REQ: begin
               sel    <= 1'b1;
               hbusy  <= 1'b0;
            end
            ST_N_STROBE:    hstb_n <= 1'b0;
            ST_N_WAIT_CLK: begin
               hstb_n <= 1'b1;
               hbusy  <= 1'b1;
            end
            ST_N_FAIL: begin
               sel    <= 1'b0;
               hbusy  <= 1'b1;
               hstb_n <= 1'b1;
            end
            ST_T_START: begin
               sel    <= 1'b0;
               hbusy  <= 1'b1;
               hstb_n <= 1'b1;
               data   <= '0;
            end
            ST_T_WAIT_BUSY: hbusy  <= 1'b0;
            ST_T_FINISH:    hbusy  <= 1'b1;
            default: ;
         endcase
      end
   end

   // Request capture, run results and link state.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q     <= '0;
         compat_q   <= 1'b1;
         flag_ref_q <= 1'b0;
         use_flag_q <= 1'b0;
         tmo_seen_q <= 1'b0;
         done       <= 1'b0;
         ok         <= 1'b0;
         timeout    <= 1'b0;
         connected  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (nxt == ST_N_PREP) begin
                  code_q   <= ext_code;
                  compat_q <= 1'b0;
                  ok       <= 1'b0;
                  timeout  <= 1'b0;
               end else if (nxt == ST_T_START) begin
                  flag_ref_q <= stat.flag;
                  use_flag_q <= (link_mode_e'(mode) != MODE_OTHER) && !xflag_ignore;
                  tmo_seen_q <= 1'b0;
                  ok         <= 1'b0;
                  timeout    <= 1'b0;
               end
            end
            ST_N_OK: begin
               done      <= 1'b1;
               ok        <= 1'b1;
               timeout   <= 1'b0;
               connected <= 1'b1;
            end
            ST_N_FAIL: begin
               done      <= 1'b1;
               ok        <= 1'b0;
               timeout   <= 1'b1;
               connected <= 1'b0;
            end
            ST_T_WAIT_CLK: begin
               if (nxt == ST_T_FINISH) tmo_seen_q <= 1'b1;
            end
            ST_T_WAIT_BUSY: begin
               if (tmr_hit && !release_ready) tmo_seen_q <= 1'b1;
            end
            ST_T_FINISH: begin
               done      <= 1'b1;
               ok        <= !tmo_seen_q;
               timeout   <= tmo_seen_q;
               connected <= 1'b0;
               compat_q  <= 1'b1;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/pport_neg_ctrl.sv
module pport_neg_ctrl
   import pport_neg_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 100_000_000,
   parameter int unsigned SETUP_NS    = 2_000,
   parameter int unsigned STROBE_NS   = 1_000,
   parameter int unsigned RESP_NS     = 35_000_000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enter_req_i,
   input  logic              term_req_i,
   input  logic [DATA_W-1:0] ext_code_i,
   input  logic [1:0]        mode_i,
   input  logic              xflag_ignore_i,
   input  logic              peer_clk_i,
   input  logic              peer_busy_i,
   input  logic              peer_ackreq_i,
   input  logic              peer_flag_i,
   input  logic              peer_avail_n_i,
   output logic              sel_o,
   output logic              hbusy_o,
   output logic              hstb_n_o,
   output logic [DATA_W-1:0] data_o,
   output logic              done_o,
   output logic              ok_o,
   output logic              timeout_o,
   output logic              connected_o
);

   localparam int unsigned SETUP_CYC  = ns2cyc(CLK_HZ, SETUP_NS);
   localparam int unsigned STROBE_CYC = ns2cyc(CLK_HZ, STROBE_NS);
   localparam int unsigned RESP_CYC   = ns2cyc(CLK_HZ, RESP_NS);
   localparam int unsigned MAX_A      = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
   localparam int unsigned MAX_CYC    = (MAX_A > RESP_CYC) ? MAX_A : RESP_CYC;
   localparam int unsigned CW         = $clog2(MAX_CYC + 1);
   localparam int unsigned STAT_W     = $bits(peer_stat_t);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (SETUP_CYC < 1 || STROBE_CYC < 1 || RESP_CYC < 1) begin : g_bad_time
      $error("every delay must be at least one clock cycle");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   peer_stat_t raw_stat, sync_stat;
   lim_sel_e   lim_sel;
   logic       tmr_clr, tmr_hit;

   assign raw_stat = '{clk:     peer_clk_i,
                       busy:    peer_busy_i,
                       ackreq:  peer_ackreq_i,
                       flag:    peer_flag_i,
                       avail_n: peer_avail_n_i};

   pport_sync #(
      .W      (STAT_W),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_stat),
      .q     (sync_stat)
   );

   pport_timer #(
      .CW         (CW),
      .SETUP_CYC  (SETUP_CYC),
      .STROBE_CYC (STROBE_CYC),
      .RESP_CYC   (RESP_CYC)
   ) tmr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .sel   (lim_sel),
      .hit   (tmr_hit)
   );

   pport_neg_fsm #(
      .DATA_W (DATA_W)
   ) fsm_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .enter_req    (enter_req_i),
      .term_req     (term_req_i),
      .ext_code     (ext_code_i),
      .mode         (mode_i),
      .xflag_ignore (xflag_ignore_i),
      .stat         (sync_stat),
      .tmr_hit      (tmr_hit),
      .tmr_clr      (tmr_clr),
      .lim_sel      (lim_sel),
      .sel          (sel_o),
      .hbusy        (hbusy_o),
      .hstb_n       (hstb_n_o),
      .data         (data_o),
      .done         (done_o),
      .ok           (ok_o),
      .timeout      (timeout_o),
      .connected    (connected_o)
   );

endmodule

// File: rtl/pport_neg_chk.sv
module pport_neg_chk #(
   parameter int unsigned STROBE_CYC = 1
) (
   input logic clk,
   input logic rst_n,
   input logic sel_o,
   input logic hbusy_o,
   input logic hstb_n_o,
   input logic done_o,
   input logic ok_o,
   input logic timeout_o,
   input logic connected_o
);

   logic [31:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        low_cnt <= '0;
      else if (!hstb_n_o) low_cnt <= low_cnt + 32'd1;
      else               low_cnt <= '0;
   end

   a_r4_strobe_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      !hstb_n_o |-> (!hbusy_o && sel_o));

   a_r4_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hstb_n_o) |-> (low_cnt >= STROBE_CYC));

   a_r4_release_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hstb_n_o) |-> hbusy_o);

   a_r5_connect_on_success: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(connected_o) |-> (done_o && ok_o));

   a_r6_timeout_drops_link: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && timeout_o) |-> (!connected_o && !sel_o && hbusy_o));

   a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r12_result_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (ok_o != timeout_o));

endmodule

bind pport_neg_ctrl pport_neg_chk #(
   .STROBE_CYC (STROBE_CYC)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .sel_o       (sel_o),
   .hbusy_o     (hbusy_o),
   .hstb_n_o    (hstb_n_o),
   .done_o      (done_o),
   .ok_o        (ok_o),
   .timeout_o   (timeout_o),
   .connected_o (connected_o)
);

// File: tb/pport_neg_ctrl_tb_top.sv
`timescale 1ns/1ps
module pport_neg_ctrl_tb_top;

   localparam int STROBE_CYC = 6;    // 30 ns at 200 MHz
   localparam int RESP_CYC   = 200;  // 1000 ns at 200 MHz

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enter_req = 1'b0, term_req = 1'b0;
   logic [7:0] ext_code = '0;
   logic [1:0] mode = 2'd0;
   logic       xign = 1'b0;
   logic       p_clk = 1'b1, p_busy = 1'b0, p_ack = 1'b0, p_flag = 1'b0, p_avail_n = 1'b1;
   logic       sel, hbusy, hstb_n, done, ok, tmo, conn;
   logic [7:0] data;

   int nvec = 0;
   int nerr = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   pport_neg_ctrl #(
      .CLK_HZ      (200_000_000),
      .SETUP_NS    (50),
      .STROBE_NS   (30),
      .RESP_NS     (1000),
      .SYNC_STAGES (2),
      .DATA_W      (8)
   ) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .enter_req_i    (enter_req),
      .term_req_i     (term_req),
      .ext_code_i     (ext_code),
      .mode_i         (mode),
      .xflag_ignore_i (xign),
      .peer_clk_i     (p_clk),
      .peer_busy_i    (p_busy),
      .peer_ackreq_i  (p_ack),
      .peer_flag_i    (p_flag),
      .peer_avail_n_i (p_avail_n),
      .sel_o          (sel),
      .hbusy_o        (hbusy),
      .hstb_n_o       (hstb_n),
      .data_o         (data),
      .done_o         (done),
      .ok_o           (ok),
      .timeout_o      (tmo),
      .connected_o    (conn)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic chk_ge(input string tag, input int act, input int lo);
      nvec++;
      if (act < lo) begin
         nerr++;
         $display("FAIL %s: actual %0d expected >= %0d", tag, act, lo);
      end
   endtask

   // which: 0 sel high, 1 sel low, 2 hbusy low, 3 strobe low, 4 strobe high, 5 done
   function automatic bit probe(input int which);
      case (which)
         0: return sel;
         1: return !sel;
         2: return !hbusy;
         3: return !hstb_n;
         4: return hstb_n;
         default: return done;
      endcase
   endfunction

   task automatic wait_until(input int which, input int max, output bit hit, output int cyc);
      hit = 1'b0;
      cyc = 0;
      while (!hit && cyc < max) begin
         @(negedge clk);
         cyc++;
         if (probe(which)) hit = 1'b1;
      end
   endtask

   task automatic peer_idle();
      p_clk = 1'b1; p_busy = 1'b0; p_ack = 1'b0; p_flag = 1'b0; p_avail_n = 1'b1;
   endtask

   task automatic pulse_enter(input logic [7:0] code);
      @(negedge clk);
      ext_code = code;
      enter_req = 1'b1;
      @(negedge clk);
      enter_req = 1'b0;
   endtask

   task automatic pulse_term(input logic [1:0] m, input logic ig);
      @(negedge clk);
      mode = m;
      xign = ig;
      term_req = 1'b1;
      @(negedge clk);
      term_req = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 sel", sel, 0);
      chk("R1 hbusy", hbusy, 1);
      chk("R1 strobe", hstb_n, 1);
      chk("R1 data", data, 0);
      chk("R1 connected", conn, 0);
      chk("R1 done", done, 0);
   endtask

   task automatic t_term_ignored();
      bit seen_done = 1'b0;
      bit moved = 1'b0;
      logic [7:0] d0 = data;
      pulse_term(2'd0, 1'b0);
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (done) seen_done = 1'b1;
         if (sel !== 1'b0 || hbusy !== 1'b1 || hstb_n !== 1'b1 || data !== d0) moved = 1'b1;
      end
      chk("R11 no completion", seen_done, 0);
      chk("R11 lines unchanged", moved, 0);
   endtask

   task automatic t_enter_ok(input logic [7:0] code);
      bit h; int c; int low;
      peer_idle();
      pulse_enter(code);
      wait_until(0, 100, h, c);
      chk("R2 select rises", h, 1);
      chk("R2 code on data", data, code);
      chk("R2 hbusy low", hbusy, 0);
      chk("R2 strobe high", hstb_n, 1);
      // three of four levels present: flag still low
      p_clk = 1'b0; p_ack = 1'b1; p_flag = 1'b0; p_avail_n = 1'b1;
      repeat (30) @(negedge clk);
      chk("R3 strobe held without flag", hstb_n, 1);
      p_flag = 1'b1;
      wait_until(3, 20, h, c);
      chk("R3 strobe falls", h, 1);
      chk("R4 hbusy low at strobe", hbusy, 0);
      chk("R4 data at strobe", data, code);
      low = 0;
      while (!hstb_n && low < 100) begin
         @(negedge clk);
         low++;
      end
      chk_ge("R4 strobe width", low, STROBE_CYC);
      chk("R4 hbusy with release", hbusy, 1);
      p_flag = 1'b0; p_avail_n = 1'b0; p_clk = 1'b1;
      wait_until(5, 50, h, c);
      chk("R5 done", h, 1);
      chk("R5 ok", ok, 1);
      chk("R5 timeout", tmo, 0);
      chk("R5 connected", conn, 1);
      chk("R5 select stays", sel, 1);
   endtask

   task automatic t_enter_tmo_ack();
      bit h; int c;
      peer_idle();
      pulse_enter(8'h11);
      wait_until(5, 2000, h, c);
      chk("R6 done", h, 1);
      chk_ge("R6 waited", c, RESP_CYC);
      chk("R6 timeout", tmo, 1);
      chk("R6 ok", ok, 0);
      chk("R6 connected", conn, 0);
      chk("R6 sel low", sel, 0);
      chk("R6 hbusy high", hbusy, 1);
   endtask

   task automatic t_enter_tmo_clk();
      bit h; int c;
      peer_idle();
      pulse_enter(8'h5A);
      wait_until(0, 100, h, c);
      p_clk = 1'b0; p_ack = 1'b1; p_flag = 1'b1; p_avail_n = 1'b1;
      wait_until(3, 50, h, c);
      wait_until(4, 50, h, c);
      chk("R6 strobe released", h, 1);
      wait_until(5, 2000, h, c);
      chk("R6 late done", h, 1);
      chk_ge("R6 late waited", c, RESP_CYC);
      chk("R6 late timeout", tmo, 1);
      chk("R6 late connected", conn, 0);
      chk("R6 late sel low", sel, 0);
   endtask

   task automatic t_term_flag();
      bit h; int c;
      p_busy = 1'b0; p_clk = 1'b1; p_flag = 1'b0;
      repeat (4) @(negedge clk);
      pulse_term(2'd0, 1'b0);
      wait_until(1, 20, h, c);
      chk("R7 sel low", h, 1);
      chk("R7 data zero", data, 0);
      chk("R7 hbusy high", hbusy, 1);
      chk("R7 strobe high", hstb_n, 1);
      p_clk = 1'b0;
      repeat (40) @(negedge clk);
      chk("R8 stalls on flag", hbusy, 1);
      p_flag = 1'b1;
      wait_until(2, 20, h, c);
      chk("R8 flag inversion advances", h, 1);
      repeat (20) @(negedge clk);
      chk("R9 waits peer busy", hbusy, 0);
      p_busy = 1'b1; p_clk = 1'b1;
      wait_until(5, 50, h, c);
      chk("R9 done", h, 1);
      chk("R9 ok", ok, 1);
      chk("R9 connected cleared", conn, 0);
      chk("R9 hbusy high", hbusy, 1);
   endtask

   task automatic t_term_noflag(input logic [1:0] m, input logic ig, input string tag);
      bit h; int c;
      p_busy = 1'b0; p_clk = 1'b1; p_flag = 1'b0;
      repeat (4) @(negedge clk);
      pulse_term(m, ig);
      wait_until(1, 20, h, c);
      p_clk = 1'b0;
      wait_until(2, 30, h, c);
      chk({"R8 flag unchecked ", tag}, h, 1);
      p_busy = 1'b1; p_clk = 1'b1;
      wait_until(5, 50, h, c);
      chk({"R9 done ", tag}, h, 1);
      chk({"R9 ok ", tag}, ok, 1);
   endtask

   task automatic t_term_tmo();
      bit h = 1'b0; int c = 0; bit dropped = 1'b0;
      p_busy = 1'b0; p_clk = 1'b1; p_flag = 1'b0;
      repeat (4) @(negedge clk);
      pulse_term(2'd2, 1'b0);
      while (!h && c < 2000) begin
         @(negedge clk);
         c++;
         if (!hbusy) dropped = 1'b1;
         if (done) h = 1'b1;
      end
      chk("R10 done", h, 1);
      chk_ge("R10 waited", c, RESP_CYC);
      chk("R10 hbusy never low", dropped, 0);
      chk("R10 timeout", tmo, 1);
      chk("R10 connected", conn, 0);
      chk("R10 hbusy high", hbusy, 1);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_term_ignored();
      t_enter_tmo_ack();
      t_enter_ok(8'hA5);
      t_term_flag();
      t_term_ignored();
      t_enter_ok(8'h3C);
      t_term_noflag(2'd0, 1'b1, "ignore");
      t_enter_ok(8'h81);
      t_term_noflag(2'd3, 1'b0, "mode3");
      t_enter_ok(8'h7E);
      t_term_tmo();
      t_enter_tmo_clk();
      summary();
   end

   initial begin
      repeat (150_000) @(posedge clk);
      if (!finished) begin
         nvec++;
         nerr++;
         $display("FAIL watchdog: actual hung expected completion");
         summary();
      end
   end

endmodule